// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block sequences parallel-mode programming of an on-chip code flash. A host sets a two-bit operation select, an address and a data byte, then pulses an active-low program strobe. When the strobe returns high the block looks at how long it was held low. A short pulse starts a self-timed program cycle. A pulse held low for at least the erase threshold, with the code operation selected, wipes the whole code array at once. The ready/busy output is low for the whole of a self-timed cycle.

Reads use a separate valid/ready request channel and a one-slot response register. A code read may be issued at any time, including while a program cycle is running. A read of the byte being programmed then returns a polling value instead of the array contents. Two lock bits block code readback. A status read reports the lock bits and the serial-programming disable fuse. That fuse can only be changed through this path, and its state is also brought out on a pin.

Top module: `pflash_seq`

## Requirements
- R1: After reset, `rdy` is 1, `rsp_valid` is 0, every code byte reads 0xFF, and both lock bits and the fuse are 0.
- R2: With `op_sel`=0 (code), a strobe low for fewer than ERASE_CYC sampled clock edges writes `wdata` to `addr`. `rdy` goes low in the cycle after the strobe's rising edge is sampled and stays low for exactly WRITE_CYC cycles. The byte becomes readable after that.
- R3: While a code write is busy, a code read of the address being written returns {~data[7], 7'b0}. Once `rdy` is high again the same read returns the true byte.
- R4: While busy, a code read of any other address returns that address's current contents.
- R5: With `op_sel`=0, a strobe low for ERASE_CYC or more sampled edges erases the chip. All code bytes become 0xFF and both lock bits clear, the fuse is kept, and `rdy` stays high. A pulse one edge shorter performs a normal write.
- R6: A strobe rising edge that arrives while `rdy` is low has no effect.
- R7: With `op_sel`=1 (lock), a short pulse ORs `wdata[1:0]` into the lock bits after WRITE_CYC busy cycles.
- R8: While either lock bit is 1, every code read returns 0x00.
- R9: A read with `op_sel` not 0 returns the status byte {5'b0, fuse, lock[1:0]}, whatever the locks are.
- R10: With `op_sel`=2 (fuse), a short pulse sets the fuse to `wdata[0]` after WRITE_CYC busy cycles, so the fuse can be both set and cleared. `ser_prog_off` shows the fuse.
- R11: `req_ready` = !`rsp_valid` || `rsp_ready`. A request is taken when `req_valid` and `req_ready` are both high. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 2 | Operation select: 0 code, 1 lock, 2 fuse, 3 reserved |
| addr | input | ADDR_W | Code byte address |
| wdata | input | 8 | Program data |
| prog_n | input | 1 | Active-low program strobe |
| rdy | output | 1 | 1 = ready, 0 = self-timed cycle running |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be taken |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read response byte |
| ser_prog_off | output | 1 | Serial-programming disable fuse state |

## Verification
The bench builds the block with ADDR_W=4, WRITE_CYC=10 and ERASE_CYC=50. With a write time of ten cycles, two polling reads and a stray strobe all fit inside one busy window. With a fifty-cycle threshold, the bench can drive pulses of exactly the threshold and one edge below it, which tests the erase/write boundary in a short run. The sixteen-byte array keeps the after-erase checks cheap.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [1:0] {
    OP_CODE = 2'd0,
    OP_LOCK = 2'd1,
    OP_FUSE = 2'd2,
    OP_RSVD = 2'd3
  } op_e;
endpackage

// File: rtl/strobe_meter.sv
module strobe_meter #(
  parameter int ERASE_CYC = 240000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  output logic rise,
  output logic long_p
);
  localparam int CW = $clog2(ERASE_CYC + 1);
  logic          prog_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      prog_q <= prog_n;
      if (prog_n)
        low_cnt <= '0;
      else if (low_cnt != CW'(ERASE_CYC))
        low_cnt <= low_cnt + 1'b1;
    end
  end

  assign rise   = prog_n & ~prog_q;
  assign long_p = (low_cnt == CW'(ERASE_CYC));
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int WRITE_CYC = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(WRITE_CYC + 1);
  logic [TW-1:0] left;

  assign done = busy && (left == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        left <= TW'(WRITE_CYC);
      end
    end else if (done) begin
      busy <= 1'b0;
      left <= '0;
    end else begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/code_store.sv
module code_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wipe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WRITE_CYC = 48000,
  parameter int ERASE_CYC = 240000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              prog_n,
  output logic              rdy,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              ser_prog_off
);
  logic              rise, long_p, busy, done;
  logic              start_wr, wipe, take;
  op_e               cur_op, pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [7:0]        pend_data, store_q, rd_val;
  logic [1:0]        lock;
  logic              fuse;

  assign cur_op = op_e'(op_sel);

  strobe_meter #(.ERASE_CYC(ERASE_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .rise(rise), .long_p(long_p)
  );

  // A strobe edge counts only while idle; a long code pulse erases instead of writing.
  assign wipe     = rise && !busy && (cur_op == OP_CODE) && long_p;
  assign start_wr = rise && !busy && (cur_op != OP_RSVD) && !wipe;

  busy_timer #(.WRITE_CYC(WRITE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_wr), .busy(busy), .done(done)
  );

  code_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(done && (pend_op == OP_CODE)), .wr_addr(pend_addr), .wr_data(pend_data),
    .wipe(wipe), .rd_addr(addr), .rd_data(store_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_op   <= OP_CODE;
      pend_addr <= '0;
      pend_data <= '0;
      lock      <= '0;
      fuse      <= 1'b0;
    end else begin
      if (start_wr) begin
        pend_op   <= cur_op;
        pend_addr <= addr;
        pend_data <= wdata;
      end
      if (wipe)
        lock <= '0;
      else if (done && pend_op == OP_LOCK)
        lock <= lock | pend_data[1:0];
      if (done && pend_op == OP_FUSE)
        fuse <= pend_data[0];
    end
  end

  always_comb begin
    if (cur_op != OP_CODE)
      rd_val = {5'b0, fuse, lock};
    else if (|lock)
      rd_val = 8'h00;
    else if (busy && pend_op == OP_CODE && addr == pend_addr)
      rd_val = {~pend_data[7], 7'b0};
    else
      rd_val = store_q;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rdy          = !busy;
  assign ser_prog_off = fuse;
endmodule

// File: rtl/pflash_seq_chk.sv
module pflash_seq_chk #(
  parameter int WRITE_CYC = 48000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_n,
  input logic       rdy,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data
);
  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)   low_run <= 0;
    else if (!rdy) low_run <= low_run + 1;
    else          low_run <= 0;
  end

  // R2: busy begins only on a sampled strobe rising edge
  a_r2_busy_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> ($past(prog_n) && !$past(prog_n, 2)));

  // R2: busy never lasts beyond the write time
  a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= WRITE_CYC);

  // R11: stalled response holds
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R11: no new request taken while stalled
  a_r11_no_take_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind pflash_seq pflash_seq_chk #(.WRITE_CYC(WRITE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .rdy(rdy), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
);

// File: tb/sim_pflash_seq.sv
`timescale 1ns/1ps
module sim_pflash_seq;
  localparam int AW = 4;
  localparam int WC = 10;
  localparam int EC = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] op_sel = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic prog_n = 1'b1;
  logic req_valid = 1'b0;
  logic rsp_ready = 1'b1;
  logic rdy, req_ready, rsp_valid, ser_prog_off;
  logic [7:0] rsp_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pflash_seq #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC)) u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .addr(addr), .wdata(wdata),
    .prog_n(prog_n), .rdy(rdy), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ser_prog_off(ser_prog_off)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected responses as they are consumed
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected response", rsp_data, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  // driver: one read request, starts and ends on a falling edge
  task automatic rd(input logic [1:0] op, input logic [AW-1:0] a,
                    input logic [7:0] e, input string tag);
    op_sel = op; addr = a; req_valid = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [7:0] d, input int n);
    op_sel = op; addr = a; wdata = d; prog_n = 1'b0;
    repeat (n) @(negedge clk);
    prog_n = 1'b1;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    @(negedge clk);
    while (!rdy) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b1, "R1 rdy", rdy, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(ser_prog_off == 1'b0, "R1 fuse pin", ser_prog_off, 0);
    rd(2'd0, 4'd3, 8'hFF, "R1 erased byte");
    rd(2'd1, 4'd0, 8'h00, "R1 R9 status after reset");

    // R2: plain write and busy length
    pulse(2'd0, 4'd2, 8'h3C, 3);
    wait_rdy(n);
    chk(n == WC, "R2 busy cycles", n, WC);
    rd(2'd0, 4'd2, 8'h3C, "R2 readback");

    // R3 R4 R6: polling, other address, strobe while busy
    pulse(2'd0, 4'd5, 8'hA5, 1);
    @(negedge clk);
    chk(rdy == 1'b0, "R2 busy started", rdy, 0);
    rd(2'd0, 4'd5, 8'h00, "R3 poll bit7 one");
    rd(2'd0, 4'd6, 8'hFF, "R4 other address while busy");
    rd(2'd0, 4'd2, 8'h3C, "R4 written address while busy");
    pulse(2'd0, 4'd7, 8'h11, 2);
    wait_rdy(n);
    rd(2'd0, 4'd5, 8'hA5, "R3 true data after busy");
    rd(2'd0, 4'd7, 8'hFF, "R6 strobe while busy ignored");
    chk(rdy == 1'b1, "R6 no busy from ignored strobe", rdy, 1);

    pulse(2'd0, 4'd8, 8'h12, 1);
    @(negedge clk);
    rd(2'd0, 4'd8, 8'h80, "R3 poll bit7 zero");
    wait_rdy(n);
    rd(2'd0, 4'd8, 8'h12, "R3 true data bit7 zero");

    // R7 R8 R9: lock bits
    pulse(2'd1, 4'd0, 8'h01, 1);
    wait_rdy(n);
    chk(n == WC, "R7 lock busy cycles", n, WC);
    rd(2'd1, 4'd0, 8'h01, "R7 lock bit set");
    rd(2'd0, 4'd2, 8'h00, "R8 locked code read");
    pulse(2'd1, 4'd0, 8'h02, 1);
    wait_rdy(n);
    rd(2'd1, 4'd0, 8'h03, "R7 lock bits accumulate");

    // R10: fuse set
    pulse(2'd2, 4'd0, 8'h01, 1);
    wait_rdy(n);
    chk(ser_prog_off == 1'b1, "R10 fuse set pin", ser_prog_off, 1);
    rd(2'd2, 4'd0, 8'h07, "R9 R10 status with fuse");

    // R5: chip erase at exactly the threshold
    pulse(2'd0, 4'd0, 8'h00, EC);
    @(negedge clk);
    chk(rdy == 1'b1, "R5 erase not busy", rdy, 1);
    rd(2'd1, 4'd0, 8'h04, "R5 locks cleared fuse kept");
    rd(2'd0, 4'd5, 8'hFF, "R5 byte erased");
    rd(2'd0, 4'd2, 8'hFF, "R5 byte erased 2");

    // R5: one edge short of the threshold is a write
    pulse(2'd0, 4'd9, 8'h5A, EC - 1);
    @(negedge clk);
    chk(rdy == 1'b0, "R5 short pulse is write", rdy, 0);
    wait_rdy(n);
    rd(2'd0, 4'd9, 8'h5A, "R5 short pulse data");
    rd(2'd0, 4'd5, 8'hFF, "R5 no erase on short pulse");

    // R10: fuse cleared
    pulse(2'd2, 4'd0, 8'h00, 1);
    wait_rdy(n);
    chk(ser_prog_off == 1'b0, "R10 fuse cleared pin", ser_prog_off, 0);

    // R11: back-pressure
    rsp_ready = 1'b0;
    rd(2'd0, 4'd9, 8'h5A, "R11 stalled response");
    chk(req_ready == 1'b0, "R11 req_ready low while stalled", req_ready, 0);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b1, "R11 valid held", rsp_valid, 1);
    chk(rsp_data == 8'h5A, "R11 data held", rsp_data, 8'h5A);
    rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule